// File: doc/BRIEF.md
# Floppy Drive Step and Head Timer

This block produces the mechanical timing that a floppy disk controller applies to its drive. Software loads two configuration bytes. The first byte holds the step interval and the head unload delay. The second byte holds the head settle delay and a flag that disables DMA. From these bytes the block paces step pulses during a seek, holds off a ready indication until the head has settled, and releases the head after a period with no accesses.

Each of the three delays is counted in its own unit, and the step interval field is encoded in reverse. A prescaler divides the system clock into a millisecond tick. When the mini-floppy mode input is high, the tick becomes two milliseconds, so every programmed delay doubles. The seek logic and the head-settle logic share one interval timer and run one at a time. The unload delay has a second timer and runs independently of them.

Top module: `drv_mech_timer`

## Requirements
- R1: After reset, stepOut, headLoad, headReady, busy and seekDone are 0, and curTrack is 0.
- R2: The step field is bits [7:4] of configuration byte 0. A value s gives an interval of (16 - s) ms between the end of one step pulse and the start of the next. One ms is CLKS_PER_MS clocks. Consecutive rising edges of stepOut are therefore at least (16 - s) ms plus PULSE_CLKS clocks apart, and no more than 3 clocks later than that.
- R3: A seek issues exactly |seekTarget - curTrack| step pulses. Each pulse moves curTrack by one toward the target. seekDone pulses once, when curTrack equals the target.
- R4: stepDir is 1 when the target is above the current track and 0 when it is below. stepDir is set one clock before the first pulse and does not change during the seek.
- R5: A seek to the track already held in curTrack produces no step pulse and raises seekDone on the next clock.
- R6: The settle field is bits [7:1] of configuration byte 1. A value h gives 2h ms, and 0 is read as 128. headReady rises no earlier than that delay after headLoad rises, and no more than 2 clocks later.
- R7: The unload field is bits [3:0] of configuration byte 0. A value u gives 16u ms, and 0 is read as 16. When that time has passed with the block idle and no access, headLoad and headReady fall.
- R8: An accessReq while the head is loaded restarts the unload delay, and headReady stays high.
- R9: While miniMode is 1, every interval in R2, R6 and R7 is twice as long.
- R10: busy is 1 during a seek and during the head settle delay, and 0 when the block is idle.
- R11: nonDma equals bit 0 of configuration byte 1.
- R12: Each step pulse is exactly PULSE_CLKS clocks wide.
- R13: A seekReq or accessReq that arrives while busy is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrStep | input | 1 | Write cfgByte into configuration byte 0 (step and unload) |
| cfgWrHead | input | 1 | Write cfgByte into configuration byte 1 (settle and DMA flag) |
| cfgByte | input | 8 | Configuration data |
| miniMode | input | 1 | Doubles every interval |
| seekReq | input | 1 | One-clock seek request |
| seekTarget | input | TRK_W | Target track |
| accessReq | input | 1 | One-clock head access request |
| stepOut | output | 1 | Step pulse |
| stepDir | output | 1 | Step direction, 1 = toward higher tracks |
| curTrack | output | TRK_W | Current track |
| seekDone | output | 1 | One-clock seek completion |
| headLoad | output | 1 | Head load drive |
| headReady | output | 1 | Head has settled |
| busy | output | 1 | Seek or settle in progress |
| nonDma | output | 1 | DMA-disable flag |

## Verification
The assertions assume that seekReq and accessReq are single-clock pulses. They also assume that a seek target stays within the track range, so curTrack never wraps. The stimulus raises each request for exactly one clock and sends every request from idle, except the one deliberately sent while busy. It rewrites the configuration bytes only between operations, so no interval changes while it is being counted.

// File: rtl/drv_mech_pkg.sv
package drv_mech_pkg;
  localparam int UNIT_W = 9;

  typedef enum logic {SEL_STEP = 1'b0, SEL_SETTLE = 1'b1} seqSel_e;

  typedef struct packed {
    logic    seqLoad;
    seqSel_e seqSel;
    logic    unlLoad;
    logic    trkInc;
    logic    trkDec;
  } dpStrobe_t;
endpackage

// File: rtl/drv_mech_dp.sv
module drv_mech_dp
  import drv_mech_pkg::*;
#(
  parameter int CLKS_PER_MS = 50000,
  parameter int TRK_W       = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrStep,
  input  logic             cfgWrHead,
  input  logic [7:0]       cfgByte,
  input  logic             miniMode,
  input  dpStrobe_t        stb,
  output logic             seqDone,
  output logic             unlDone,
  output logic [TRK_W-1:0] curTrack,
  output logic             nonDma
);
  localparam int PRE_W = $clog2(2 * CLKS_PER_MS + 1);
  localparam int NCH   = 2;

  logic [7:0] cfgStep, cfgHead;
  logic [UNIT_W-1:0] stepUnits, settleUnits, unloadUnits;
  logic [PRE_W-1:0]  preLast;
  logic [NCH-1:0][UNIT_W-1:0] chUnits;
  logic [NCH-1:0] chLoad, chDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgStep <= '0;
      cfgHead <= '0;
    end else begin
      if (cfgWrStep) cfgStep <= cfgByte;
      if (cfgWrHead) cfgHead <= cfgByte;
    end
  end

  assign nonDma = cfgHead[0];

  // reversed step code, 2 ms settle units, 16 ms unload units
  always_comb begin
    stepUnits   = UNIT_W'(5'd16 - {1'b0, cfgStep[7:4]});
    settleUnits = (cfgHead[7:1] == 7'd0) ? UNIT_W'(256)
                                         : UNIT_W'({cfgHead[7:1], 1'b0});
    unloadUnits = (cfgStep[3:0] == 4'd0) ? UNIT_W'(256)
                                         : UNIT_W'({cfgStep[3:0], 4'b0});
    preLast     = miniMode ? PRE_W'(2 * CLKS_PER_MS - 1)
                           : PRE_W'(CLKS_PER_MS - 1);
  end

  assign chUnits[0] = (stb.seqSel == SEL_STEP) ? stepUnits : settleUnits;
  assign chUnits[1] = unloadUnits;
  assign chLoad[0]  = stb.seqLoad;
  assign chLoad[1]  = stb.unlLoad;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_tmr
    logic [PRE_W-1:0]  pre;
    logic [UNIT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pre <= '0;
        cnt <= '0;
      end else if (chLoad[ch]) begin
        pre <= '0;
        cnt <= chUnits[ch];
      end else if (cnt != '0) begin
        if (pre >= preLast) begin
          pre <= '0;
          cnt <= cnt - 1'b1;
        end else begin
          pre <= pre + 1'b1;
        end
      end
    end
    assign chDone[ch] = (cnt == '0);
  end

  assign seqDone = chDone[0];
  assign unlDone = chDone[1];

  always_ff @(posedge clk) begin
    if (!rstN)           curTrack <= '0;
    else if (stb.trkInc) curTrack <= curTrack + 1'b1;
    else if (stb.trkDec) curTrack <= curTrack - 1'b1;
  end

  assert_track_moves_by_one_R3: assert property (@(posedge clk) disable iff (!rstN)
    (curTrack != $past(curTrack)) |->
      (curTrack == $past(curTrack) + 1'b1 || curTrack == $past(curTrack) - 1'b1));
endmodule

// File: rtl/drv_mech_ctrl.sv
module drv_mech_ctrl
  import drv_mech_pkg::*;
#(
  parameter int TRK_W      = 7,
  parameter int PULSE_CLKS = 100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             seekReq,
  input  logic [TRK_W-1:0] seekTarget,
  input  logic             accessReq,
  input  logic             seqDone,
  input  logic             unlDone,
  input  logic [TRK_W-1:0] curTrack,
  output dpStrobe_t        stb,
  output logic             stepOut,
  output logic             stepDir,
  output logic             seekDone,
  output logic             headLoad,
  output logic             headReady,
  output logic             busy
);
  localparam int PW_W = $clog2(PULSE_CLKS + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_DIR, ST_PULSE, ST_GAP, ST_SETTLE} state_e;

  state_e state;
  logic [TRK_W-1:0] tgt;
  logic [PW_W-1:0]  pulseCnt;
  logic             pulseEnd;

  assign busy     = (state != ST_IDLE);
  assign stepOut  = (state == ST_PULSE);
  assign pulseEnd = (state == ST_PULSE) && (pulseCnt == PW_W'(PULSE_CLKS - 1));

  always_comb begin
    stb         = '0;
    stb.seqSel  = SEL_STEP;
    stb.trkInc  = pulseEnd && stepDir;
    stb.trkDec  = pulseEnd && !stepDir;
    stb.seqLoad = pulseEnd;
    if (state == ST_IDLE && !seekReq && accessReq && !headLoad) begin
      stb.seqLoad = 1'b1;
      stb.seqSel  = SEL_SETTLE;
    end
    stb.unlLoad = busy || (state == ST_IDLE && accessReq);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      tgt       <= '0;
      stepDir   <= 1'b0;
      pulseCnt  <= '0;
      seekDone  <= 1'b0;
      headLoad  <= 1'b0;
      headReady <= 1'b0;
    end else begin
      seekDone <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (seekReq) begin
            tgt <= seekTarget;
            if (seekTarget == curTrack) begin
              seekDone <= 1'b1;
            end else begin
              stepDir <= (seekTarget > curTrack);
              state   <= ST_DIR;
            end
          end else if (accessReq) begin
            if (!headLoad) begin
              headLoad <= 1'b1;
              state    <= ST_SETTLE;
            end
          end else if (headLoad && unlDone) begin
            headLoad  <= 1'b0;
            headReady <= 1'b0;
          end
        end
        ST_DIR: begin
          pulseCnt <= '0;
          state    <= ST_PULSE;
        end
        ST_PULSE: begin
          pulseCnt <= pulseCnt + 1'b1;
          if (pulseEnd) state <= ST_GAP;
        end
        ST_GAP: begin
          if (seqDone) begin
            if (curTrack == tgt) begin
              seekDone <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              pulseCnt <= '0;
              state    <= ST_PULSE;
            end
          end
        end
        ST_SETTLE: begin
          if (seqDone) begin
            headReady <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_ready_needs_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    headReady |-> headLoad);
  assert_dir_steady_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stepOut && $past(busy)) |-> $stable(stepDir));
  assert_seek_lands_R3: assert property (@(posedge clk) disable iff (!rstN)
    seekDone |-> (curTrack == tgt));
  assert_unload_when_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(headLoad) |-> !busy);
  assert_track_only_in_gap_R12: assert property (@(posedge clk) disable iff (!rstN)
    (curTrack != $past(curTrack)) |-> (state == ST_GAP));
endmodule

// File: rtl/drv_mech_timer.sv
module drv_mech_timer
  import drv_mech_pkg::*;
#(
  parameter int CLKS_PER_MS = 50000,
  parameter int TRK_W       = 7,
  parameter int PULSE_CLKS  = 100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrStep,
  input  logic             cfgWrHead,
  input  logic [7:0]       cfgByte,
  input  logic             miniMode,
  input  logic             seekReq,
  input  logic [TRK_W-1:0] seekTarget,
  input  logic             accessReq,
  output logic             stepOut,
  output logic             stepDir,
  output logic [TRK_W-1:0] curTrack,
  output logic             seekDone,
  output logic             headLoad,
  output logic             headReady,
  output logic             busy,
  output logic             nonDma
);
  dpStrobe_t stb;
  logic seqDone, unlDone;

  drv_mech_ctrl #(.TRK_W(TRK_W), .PULSE_CLKS(PULSE_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .seekReq(seekReq), .seekTarget(seekTarget),
    .accessReq(accessReq), .seqDone(seqDone), .unlDone(unlDone),
    .curTrack(curTrack), .stb(stb), .stepOut(stepOut), .stepDir(stepDir),
    .seekDone(seekDone), .headLoad(headLoad), .headReady(headReady), .busy(busy)
  );

  drv_mech_dp #(.CLKS_PER_MS(CLKS_PER_MS), .TRK_W(TRK_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrStep(cfgWrStep), .cfgWrHead(cfgWrHead),
    .cfgByte(cfgByte), .miniMode(miniMode), .stb(stb), .seqDone(seqDone),
    .unlDone(unlDone), .curTrack(curTrack), .nonDma(nonDma)
  );
endmodule

// File: tb/sim_drv_mech_timer.sv
module sim_drv_mech_timer;
  localparam int CPM = 4;
  localparam int TW  = 7;
  localparam int PW  = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWrStep = 0, cfgWrHead = 0, miniMode = 0, seekReq = 0, accessReq = 0;
  logic [7:0] cfgByte = 0;
  logic [TW-1:0] seekTarget = 0;
  logic stepOut, stepDir, seekDone, headLoad, headReady, busy, nonDma;
  logic [TW-1:0] curTrack;

  int nChecks = 0, nFails = 0, cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  drv_mech_timer #(.CLKS_PER_MS(CPM), .TRK_W(TW), .PULSE_CLKS(PW)) u0 (
    .clk(clk), .rstN(rstN), .cfgWrStep(cfgWrStep), .cfgWrHead(cfgWrHead),
    .cfgByte(cfgByte), .miniMode(miniMode), .seekReq(seekReq),
    .seekTarget(seekTarget), .accessReq(accessReq), .stepOut(stepOut),
    .stepDir(stepDir), .curTrack(curTrack), .seekDone(seekDone),
    .headLoad(headLoad), .headReady(headReady), .busy(busy), .nonDma(nonDma)
  );

  // {step nibble, 3'b0, mini, target}
  localparam int NV = 5;
  localparam logic [15:0] VEC [NV] = '{
    {4'hF, 3'b0, 1'b0, 8'd3},
    {4'hE, 3'b0, 1'b1, 8'd1},
    {4'h0, 3'b0, 1'b0, 8'd5},
    {4'hC, 3'b0, 1'b0, 8'd5},
    {4'hD, 3'b0, 1'b1, 8'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrCfg(input bit head, input logic [7:0] v);
    @(negedge clk);
    cfgByte = v; cfgWrStep = !head; cfgWrHead = head;
    @(negedge clk);
    cfgWrStep = 0; cfgWrHead = 0;
  endtask

  task automatic doSeek(input int tgt, input int unitMs, input string tag);
    int pulses = 0, cyc = 0, lastRise = -1, minGap = 1 << 30, maxGap = 0;
    int widthBad = 0, dirBad = 0, wcnt = 0, startTrk;
    bit prev = 0, done = 0, expDir;
    int nClk = unitMs * CPM * (miniMode ? 2 : 1);
    startTrk = curTrack;
    expDir = tgt > startTrk;
    @(negedge clk);
    seekTarget = TW'(tgt); seekReq = 1;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      seekReq = 0;
      cyc++;
      if (stepOut) begin
        wcnt++;
        if (!prev) begin
          pulses++;
          if (stepDir != expDir) dirBad++;
          if (lastRise >= 0) begin
            if (cyc - lastRise < minGap) minGap = cyc - lastRise;
            if (cyc - lastRise > maxGap) maxGap = cyc - lastRise;
          end
          lastRise = cyc;
        end
      end else if (prev) begin
        if (wcnt != PW) widthBad++;
        wcnt = 0;
      end
      prev = stepOut;
      if (seekDone) done = 1;
    end
    check(done, {tag, " R3 seekDone"}, done, 1);
    check(pulses == ((tgt > startTrk) ? tgt - startTrk : startTrk - tgt),
          {tag, " R3 pulse count"}, pulses, (tgt > startTrk) ? tgt - startTrk : startTrk - tgt);
    check(curTrack == TW'(tgt), {tag, " R3 final track"}, curTrack, tgt);
    check(widthBad == 0, {tag, " R12 pulse width"}, widthBad, 0);
    if (pulses > 0) check(dirBad == 0, {tag, " R4 direction"}, dirBad, 0);
    else check(cyc == 1, {tag, " R5 immediate completion"}, cyc, 1);
    if (pulses > 1) begin
      check(minGap >= nClk + PW, {tag, " R2/R9 min step gap"}, minGap, nClk + PW);
      check(maxGap <= nClk + PW + 3, {tag, " R2/R9 max step gap"}, maxGap, nClk + PW + 3);
    end
  endtask

  // returns clocks from headLoad rise to headReady rise
  task automatic doLoad(output int lat);
    int cyc = 0;
    bit seen = 0, busyOk = 1;
    lat = -1;
    @(negedge clk);
    accessReq = 1;
    while (lat < 0 && cyc < 20000) begin
      @(negedge clk);
      accessReq = 0;
      if (headLoad) seen = 1;
      if (seen && !headReady && !busy) busyOk = 0;
      if (seen) cyc++;
      if (headReady) lat = cyc - 1;
    end
    check(busyOk, "R10 busy during settle", busyOk, 1);
  endtask

  task automatic waitDrop(output int t);
    t = 0;
    while (headLoad && t < 20000) begin
      @(negedge clk);
      t++;
    end
  endtask

  initial begin
    int lat, t, e;
    bit rdyHeld;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!stepOut && !headLoad && !headReady && !busy && !seekDone,
          "R1 outputs idle in reset", {stepOut, headLoad, headReady, busy, seekDone}, 0);
    rstN = 1;
    @(negedge clk);
    check(curTrack == 0, "R1 track zero", curTrack, 0);
    check(!busy, "R1/R10 idle after reset", busy, 0);

    for (int i = 0; i < NV; i++) begin
      miniMode = VEC[i][8];
      wrCfg(0, {VEC[i][15:12], 4'h2});
      doSeek(int'(VEC[i][7:0]), 16 - int'(VEC[i][15:12]), $sformatf("vec%0d", i));
      check(!busy, "R10 idle after seek", busy, 0);
    end

    // R11 DMA flag follows byte 1 bit 0
    miniMode = 0;
    wrCfg(1, 8'h09);
    check(nonDma == 1, "R11 flag set", nonDma, 1);
    wrCfg(1, 8'h08);
    check(nonDma == 0, "R11 flag clear", nonDma, 0);

    // R6 settle h=4 -> 8 ms; unload u=2 -> 32 ms
    wrCfg(0, 8'hF2);
    e = 8 * CPM;
    doLoad(lat);
    check(lat >= e && lat <= e + 2, "R6 settle delay", lat, e);
    waitDrop(t);
    e = 32 * CPM;
    check(t >= e && t <= e + 2, "R7 unload delay", t, e);
    check(!headReady, "R7 ready dropped", headReady, 0);

    // R8 access while loaded restarts unload
    doLoad(lat);
    repeat (60) @(negedge clk);
    @(negedge clk); accessReq = 1;
    @(negedge clk); accessReq = 0;
    t = 1; rdyHeld = 1;
    while (headLoad && t < 20000) begin
      @(negedge clk);
      if (headLoad && !headReady) rdyHeld = 0;
      t++;
    end
    check(t >= e && t <= e + 3, "R8 unload restarted", t, e);
    check(rdyHeld, "R8 ready held", rdyHeld, 1);

    // R9 mini mode doubles settle and unload
    miniMode = 1;
    doLoad(lat);
    check(lat >= 16 * CPM && lat <= 16 * CPM + 2, "R9 mini settle", lat, 16 * CPM);
    waitDrop(t);
    check(t >= 64 * CPM && t <= 64 * CPM + 2, "R9 mini unload", t, 64 * CPM);
    miniMode = 0;

    // R13 seek while settling is ignored
    @(negedge clk); accessReq = 1;
    @(negedge clk); accessReq = 0;
    seekTarget = 7'd9; seekReq = 1;
    @(negedge clk); seekReq = 0;
    t = 0;
    while (!headReady && t < 20000) begin
      @(negedge clk);
      if (stepOut) t = 30000;
      t++;
    end
    repeat (5) @(negedge clk);
    check(t < 20000, "R13 no step while busy", t, 0);
    check(curTrack == 0, "R13 track unchanged", curTrack, 0);
    check(!busy, "R13 no queued seek", busy, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule